// File: doc/BRIEF.md
# PWM Duty Meter with Edge Timestamps

The block measures an incoming pulse-width-modulated signal in units of its own clock. It runs a free counter, stamps the counter value on an accepted rising edge and again on the next accepted falling edge, and turns the difference into a high-time figure. That high time is then scaled against a nominal period, which the user supplies in clock ticks, to give a whole-number duty percentage. The width and the percentage are presented together with a one-cycle strobe.

The input passes through a synchronizer. Edges that last only a single clock are thrown away. The block always knows which polarity it is waiting for. After reset it waits for a rising edge, and after each accepted edge it waits for the opposite one. When a pulse's high time runs past one nominal period, the block treats this as a missed edge and takes one period off the figure. It then limits the result to a full period.

If the input stops toggling, a stall counter expires after two nominal periods plus a fixed margin. The block then reports exactly 0 % when the line is low and exactly 100 % when it is high. It reports this once for each stall. The nominal period must be nonzero and at least 24 ticks. It must be held steady while a measurement is being divided.

Top module: `pwm_duty_meter`

## Requirements
- R1: While rst_n is low, valid, duty_pct and pulse_width are all 0.
- R2: A high or low excursion of the input that lasts one clock cycle is ignored and produces no result. An excursion of two cycles or more is a real level change.
- R3: After reset the block waits for a rising edge. A falling edge that arrives while a rising edge is awaited is ignored, for example the trailing edge of a rejected one-cycle high pulse.
- R4: The raw width is the number of clock cycles between the accepted rising edge and the following accepted falling edge. It is taken modulo 2^16 on a 16-bit counter, so counter wraparound gives the correct value.
- R5: If the raw width exceeds nom_period, nom_period is subtracted once. The result is then limited to at most nom_period, and that limited value is driven on pulse_width.
- R6: duty_pct equals floor(pulse_width * 100 / nom_period) and is never above 100.
- R7: Each result is marked by valid high for exactly one cycle. Every accepted falling edge produces exactly one result.
- R8: If no edge is accepted for 2*nom_period + 16 cycles, the block produces one result. The result is duty 0 and width 0 when the synchronized input is low, and duty 100 and width nom_period when it is high. No further result follows until another edge is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Signal under measurement, asynchronous |
| nom_period | input | 16 | Nominal period in clock ticks, nonzero |
| duty_pct | output | 7 | Duty cycle in whole percent, 0 to 100 |
| pulse_width | output | 16 | Corrected high time in ticks |
| valid | output | 1 | One-cycle strobe marking a new result |

## Verification
Three situations are hard to reach from the pins: the stall timeout while the line is held high, the subtract-then-limit path, and the interplay of a rejected one-cycle pulse with the awaited polarity. The stimulus reaches each with a directed case. One case holds the line high beyond two periods, so a 100 % timeout result is followed by a limited width when the line finally falls. Another case places single-cycle glitches inside both the low and the high phase. Several hundred random periods with mixed duty and occasional overlong pulses then run past the 16-bit counter wrap.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  localparam int PCT_FULL = 100;
  localparam int PCT_W    = $clog2(PCT_FULL + 1);
endpackage

// File: rtl/pdm_sync_edge.sv
module pdm_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise_ok,
  output logic fall_ok
);
  localparam int DEPTH = STAGES + 2;

  logic [DEPTH-1:0] sr_q, sr_nx;
  logic             ahead, prev;

  always_comb begin
    sr_nx   = {sr_q[DEPTH-2:0], din};
    ahead   = sr_q[STAGES-1];
    level   = sr_q[STAGES];
    prev    = sr_q[STAGES+1];
    // an edge counts only if the new level is still present one cycle later
    rise_ok = level & ~prev & ahead;
    fall_ok = ~level & prev & ~ahead;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_nx;
  end
endmodule

// File: rtl/pdm_capture.sv
module pdm_capture #(
  parameter int CNT_W  = 16,
  parameter int MARGIN = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             level,
  input  logic             rise_ok,
  input  logic             fall_ok,
  input  logic [CNT_W-1:0] period,
  output logic             start,
  output logic [CNT_W-1:0] width,
  output logic             fire,
  output logic             fire_high
);
  localparam int IDL_W = CNT_W + 2;

  logic [CNT_W-1:0] cnt_q, cnt_nx, trise_q, trise_nx, raw, adj;
  logic             exp_rise_q, exp_rise_nx, cap_r, cap_f, cap;
  logic [IDL_W-1:0] idle_q, idle_nx, win;

  always_comb begin
    cap_r     = exp_rise_q & rise_ok;
    cap_f     = ~exp_rise_q & fall_ok;
    cap       = cap_r | cap_f;
    raw       = cnt_q - trise_q;
    adj       = (raw > period) ? (raw - period) : raw;
    width     = (adj > period) ? period : adj;
    start     = cap_f;
    win       = (IDL_W'(period) << 1) + IDL_W'(MARGIN);
    fire      = (idle_q == win) && !cap;
    fire_high = level;

    cnt_nx      = cnt_q + 1'b1;
    trise_nx    = trise_q;
    exp_rise_nx = exp_rise_q;
    if (cap_r) begin
      trise_nx    = cnt_q;
      exp_rise_nx = 1'b0;
    end
    if (cap_f) exp_rise_nx = 1'b1;

    idle_nx = idle_q;
    if (cap)               idle_nx = '0;
    else if (idle_q <= win) idle_nx = idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      trise_q    <= '0;
      exp_rise_q <= 1'b1;
      idle_q     <= '0;
    end else begin
      cnt_q      <= cnt_nx;
      trise_q    <= trise_nx;
      exp_rise_q <= exp_rise_nx;
      idle_q     <= idle_nx;
    end
  end

  // R5: the width handed to the divider never exceeds one period
  a_r5_width_limited: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (width <= period));

  // R8: a stall is reported once, not on consecutive cycles
  a_r8_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
endmodule

// File: rtl/pdm_divider.sv
module pdm_divider #(
  parameter int CNT_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [CNT_W-1:0]         width,
  input  logic [CNT_W-1:0]         den,
  output logic                     done,
  output logic [pdm_pkg::PCT_W-1:0] quo,
  output logic [CNT_W-1:0]         tag
);
  import pdm_pkg::*;
  localparam int NUM_W  = CNT_W + PCT_W;
  localparam int STEP_W = $clog2(NUM_W + 1);
  localparam int EXT_W  = NUM_W + CNT_W;

  logic              busy_q, busy_nx, done_q, done_nx, ge;
  logic [STEP_W-1:0] step_q, step_nx;
  logic [NUM_W-1:0]  num_q, num_nx, quo_q, quo_nx;
  logic [CNT_W-1:0]  rem_q, rem_nx, den_q, den_nx, tag_q, tag_nx;
  logic [CNT_W:0]    rem_sh, diff;

  always_comb begin
    rem_sh  = {rem_q, num_q[NUM_W-1]};
    diff    = rem_sh - {1'b0, den_q};
    ge      = (rem_sh >= {1'b0, den_q});
    busy_nx = busy_q;
    step_nx = step_q;
    num_nx  = num_q;
    quo_nx  = quo_q;
    rem_nx  = rem_q;
    den_nx  = den_q;
    tag_nx  = tag_q;
    done_nx = 1'b0;
    if (start) begin
      busy_nx = 1'b1;
      step_nx = '0;
      num_nx  = NUM_W'(width) * NUM_W'(PCT_FULL);
      quo_nx  = '0;
      rem_nx  = '0;
      den_nx  = den;
      tag_nx  = width;
    end else if (busy_q) begin
      num_nx  = num_q << 1;
      rem_nx  = ge ? diff[CNT_W-1:0] : rem_sh[CNT_W-1:0];
      quo_nx  = {quo_q[NUM_W-2:0], ge};
      step_nx = step_q + 1'b1;
      if (step_q == STEP_W'(NUM_W - 1)) begin
        busy_nx = 1'b0;
        done_nx = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      num_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      tag_q  <= '0;
    end else begin
      busy_q <= busy_nx;
      done_q <= done_nx;
      step_q <= step_nx;
      num_q  <= num_nx;
      quo_q  <= quo_nx;
      rem_q  <= rem_nx;
      den_q  <= den_nx;
      tag_q  <= tag_nx;
    end
  end

  assign done = done_q;
  assign quo  = quo_q[PCT_W-1:0];
  assign tag  = tag_q;

  // R6: the finished quotient and remainder reproduce width*100
  a_r6_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((EXT_W'(quo_q) * EXT_W'(den_q) + EXT_W'(rem_q)) ==
                (EXT_W'(tag_q) * EXT_W'(PCT_FULL))) && (rem_q < den_q));
endmodule

// File: rtl/pwm_duty_meter.sv
module pwm_duty_meter #(
  parameter int CNT_W  = 16,
  parameter int MARGIN = 16,
  parameter int STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pwm_in,
  input  logic [CNT_W-1:0]          nom_period,
  output logic [pdm_pkg::PCT_W-1:0] duty_pct,
  output logic [CNT_W-1:0]          pulse_width,
  output logic                      valid
);
  import pdm_pkg::*;

  logic             level, rise_ok, fall_ok, start, fire, fire_high, done;
  logic [CNT_W-1:0] cap_width, tag;
  logic [PCT_W-1:0] quo;

  logic             valid_q, valid_nx;
  logic [PCT_W-1:0] pct_q, pct_nx;
  logic [CNT_W-1:0] wid_q, wid_nx;

  pdm_sync_edge #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pwm_in),
    .level(level), .rise_ok(rise_ok), .fall_ok(fall_ok)
  );

  pdm_capture #(.CNT_W(CNT_W), .MARGIN(MARGIN)) u_cap (
    .clk(clk), .rst_n(rst_n), .level(level), .rise_ok(rise_ok),
    .fall_ok(fall_ok), .period(nom_period), .start(start),
    .width(cap_width), .fire(fire), .fire_high(fire_high)
  );

  pdm_divider #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start), .width(cap_width),
    .den(nom_period), .done(done), .quo(quo), .tag(tag)
  );

  always_comb begin
    valid_nx = 1'b0;
    pct_nx   = pct_q;
    wid_nx   = wid_q;
    if (fire) begin
      valid_nx = 1'b1;
      pct_nx   = fire_high ? PCT_W'(PCT_FULL) : '0;
      wid_nx   = fire_high ? nom_period : '0;
    end else if (done) begin
      valid_nx = 1'b1;
      pct_nx   = quo;
      wid_nx   = tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      pct_q   <= '0;
      wid_q   <= '0;
    end else begin
      valid_q <= valid_nx;
      pct_q   <= pct_nx;
      wid_q   <= wid_nx;
    end
  end

  assign valid       = valid_q;
  assign duty_pct    = pct_q;
  assign pulse_width = wid_q;

  // R7: the strobe is a single-cycle pulse
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  // R6: a reported duty never exceeds full scale
  a_r6_duty_max: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (duty_pct <= PCT_W'(PCT_FULL)));
endmodule

// File: tb/sim_pwm_duty_meter.sv
module sim_pwm_duty_meter;
  localparam int MRG = 16;

  logic        clk, rst_n, pwm_in, valid, valid_prev;
  logic [15:0] nom_period, pulse_width;
  logic [6:0]  duty_pct;
  int          tests, fails;
  int          q_pct[$];
  int          q_w[$];
  string       q_tag[$];

  pwm_duty_meter u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .nom_period(nom_period),
    .duty_pct(duty_pct), .pulse_width(pulse_width), .valid(valid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int exp_w(int h, int p);
    int w;
    w = h;
    if (w > p) w = w - p;
    if (w > p) w = p;
    return w;
  endfunction

  task automatic expect_res(int w, int p, string tag);
    q_w.push_back(w);
    q_pct.push_back((w * 100) / p);
    q_tag.push_back(tag);
  endtask

  task automatic hold(logic v, int n);
    pwm_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(int h, int l, string tag);
    expect_res(exp_w(h, int'(nom_period)), int'(nom_period), tag);
    hold(1'b1, h);
    hold(1'b0, l);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid && valid_prev) begin
        tests++; fails++;
        $display("FAIL R7 valid high two cycles: actual 1 expected 0");
      end
      if (valid) begin
        tests++;
        if (q_w.size() == 0) begin
          fails++;
          $display("FAIL R7 unexpected result: actual pct=%0d w=%0d expected none",
                   duty_pct, pulse_width);
        end else begin
          if (int'(duty_pct) != q_pct[0] || int'(pulse_width) != q_w[0]) begin
            fails++;
            $display("FAIL %s: actual pct=%0d w=%0d expected pct=%0d w=%0d",
                     q_tag[0], duty_pct, pulse_width, q_pct[0], q_w[0]);
          end
          void'(q_pct.pop_front());
          void'(q_w.pop_front());
          void'(q_tag.pop_front());
        end
      end
    end
    valid_prev = valid;
  end

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    tests = 0; fails = 0; valid_prev = 1'b0;
    void'($urandom(32'd4711));
    rst_n = 1'b0; pwm_in = 1'b0; nom_period = 16'd200;
    repeat (5) @(negedge clk);
    tests++;
    if (valid !== 1'b0 || duty_pct !== 7'd0 || pulse_width !== 16'd0) begin
      fails++;
      $display("FAIL R1 reset outputs: actual v=%b pct=%0d w=%0d expected 0 0 0",
               valid, duty_pct, pulse_width);
    end
    rst_n = 1'b1;
    // R8: idle low after reset gives a 0 % report
    expect_res(0, 200, "R8 low stall after reset");
    hold(1'b0, 2 * 200 + MRG + 30);
    // R4 R6 plain pulses, including the shortest accepted one
    pulse(50, 150, "R4 R6 quarter duty");
    pulse(2, 198, "R4 R6 two-cycle pulse");
    // R2 R3: one-cycle high glitch in the low phase is dropped
    expect_res(60, 200, "R2 R3 glitch in low phase");
    hold(1'b1, 60); hold(1'b0, 30); hold(1'b1, 1); hold(1'b0, 100);
    // R2: one-cycle low glitch in the high phase is dropped
    expect_res(81, 200, "R2 glitch in high phase");
    hold(1'b1, 40); hold(1'b0, 1); hold(1'b1, 40); hold(1'b0, 150);
    // R5: overlong pulse loses one period
    pulse(230, 150, "R5 missed edge correction");
    // R8: low stall after a result
    expect_res(0, 200, "R8 low stall");
    hold(1'b0, 2 * 200 + MRG + 50);
    // R8 then R5: high stall, then a limited width on the late fall
    expect_res(200, 200, "R8 high stall");
    expect_res(200, 200, "R5 limit after high stall");
    hold(1'b1, 2 * 200 + MRG + 50);
    hold(1'b0, 150);
    // random periods; run long enough to wrap the counter (R4)
    for (int i = 0; i < 300; i++) begin
      int p, h, l;
      p = int'($urandom_range(100, 400));
      nom_period = 16'(p);
      if ($urandom_range(0, 7) == 0) begin
        h = int'($urandom_range(p + 1, p + 60));
        l = 60;
      end else begin
        h = int'($urandom_range(2, p - 40));
        l = p - h;
      end
      pulse(h, l, "R4 R5 R6 random period");
    end
    hold(1'b0, 100);
    tests++;
    if (q_w.size() != 0) begin
      fails++;
      $display("FAIL R7 missing results: actual %0d pending expected 0", q_w.size());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule